// File: doc/BRIEF.md
# Scalar Bit Manipulation Unit

This unit executes the bit-level scalar operations of a processor datapath on 32-bit operands. Each accepted request carries an opcode and two source operands. One clock later the unit returns a 32-bit result and a one-bit condition flag. The operation set covers the following:

- bit-field mask generation and extraction
- two nibble-group reductions: a fill and a packed mask
- bit reversal
- zero and one population counts
- lowest-bit searches
- leading-bit searches from the MSB, in unsigned and sign-aware forms

Issue logic drives `valid_i` with the opcode and operands for a single cycle. `valid_o` rises on the next cycle, with `result_o` and `flag_o` for that request. The outputs keep their last values while no request is presented. Searches that find nothing return all ones, which is -1 as a signed value.

Top module: `sbit_unit`

## Requirements
- R1: Results are registered. `valid_o` equals `valid_i` of the previous cycle. The result and flag of a request appear in the cycle after it is accepted. While `valid_i` is low, `result_o` and `flag_o` hold their values.
- R2: Opcode 0 (field mask) uses `src_a_i[5:0]` as the size s and `src_b_i[4:0]` as the position p. It returns ones in bits p to p+w-1, where w = min(s, 32-p), and zeros elsewhere.
- R3: Opcode 1 (field extract) takes its data from `src_a_i`, the offset p from `src_b_i[4:0]` and the width from `src_b_i[22:16]`. The width is clamped to 32-p. The selected field is returned right-aligned and zero-extended.
- R4: Opcode 2 (nibble fill) returns, for each aligned group of 4 bits, all ones in that group if any input bit of the group is 1, and zeros otherwise.
- R5: Opcode 3 (nibble pack) returns an 8-bit value in bits [7:0], zero-extended. Bit g is 1 when any bit of `src_a_i[4g+3:4g]` is 1.
- R6: Opcode 4 returns `src_a_i` with its bit order reversed.
- R7: Opcode 5 returns the number of zero bits of `src_a_i`, and opcode 6 returns the number of one bits.
- R8: Opcode 7 returns the index of the lowest 0 bit of `src_a_i`, and opcode 8 the index of the lowest 1 bit. When no bit matches, the result is 32'hFFFFFFFF.
- R9: Opcode 9 returns the number of zero bits above the highest 1 of `src_a_i`, or 32'hFFFFFFFF when the operand is zero.
- R10: Opcode 10 returns the distance from the MSB to the highest bit that differs from bit 31. When no bit differs (operand 0 or all ones), it returns 32'hFFFFFFFF.
- R11: For opcodes 0 to 6, `flag_o` is 1 exactly when the result is nonzero. For opcodes 7 to 10, `flag_o` is 1 exactly when the result is neither 0 nor 32'hFFFFFFFF.
- R12: Opcodes 11 to 15 return result 0 with the flag at 0.
- R13: While `rst_ni` is low, `valid_o`, `result_o` and `flag_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Opcode |
| src_a_i | input | 32 | First operand |
| src_b_i | input | 32 | Second operand |
| valid_o | output | 1 | Result strobe, one cycle after `valid_i` |
| result_o | output | 32 | Result |
| flag_o | output | 1 | Condition flag |

## Verification
The bench targets the clamping corners of the field operations:

- A field mask whose size overruns bit 31 would wrap into the low bits if the clamp were missing.
- An extract offset with bit 5 set would shift the whole word out if more than five bits were used.
- A zero extract width would return data instead of zero.

The search opcodes are driven with all-zero and all-one operands and with matches at index 0:

- A wrong not-found value, or a flag left high on -1, shows there.
- So does a flag left high for a match at bit 0.

The sign-aware leading search is fed 1, 0x40000000 and 0xFFFFFFFE. An off-by-one, or a search that includes the sign bit, returns a value one too large or 0 there.

Idle cycles between requests confirm that the outputs hold their values.

// File: rtl/sbit_pkg.sv
package sbit_pkg;
  typedef enum logic [3:0] {
    OP_FMASK = 4'd0,
    OP_FEXT  = 4'd1,
    OP_QFILL = 4'd2,
    OP_QPACK = 4'd3,
    OP_REV   = 4'd4,
    OP_CNT0  = 4'd5,
    OP_CNT1  = 4'd6,
    OP_FIND0 = 4'd7,
    OP_FIND1 = 4'd8,
    OP_LEADU = 4'd9,
    OP_LEADS = 4'd10
  } sbit_op_e;
endpackage

// File: rtl/sbit_field.sv
module sbit_field #(
  parameter int DATA_W  = 32,
  parameter int WID_LSB = 16,
  parameter int WID_W   = 7
) (
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] ext_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int SZ_W  = IDX_W + 1;
  localparam int CW    = (WID_W > SZ_W) ? WID_W : SZ_W;

  logic [IDX_W-1:0]  pos;
  logic [CW-1:0]     room, size_m, size_x, w_m, w_x;
  logic [DATA_W-1:0] low_m, low_x;

  assign pos    = src_b_i[IDX_W-1:0];
  assign room   = CW'(DATA_W) - CW'(pos);
  assign size_m = CW'(src_a_i[SZ_W-1:0]);
  assign size_x = CW'(src_b_i[WID_LSB +: WID_W]);
  // clamp so the field stops at the MSB
  assign w_m    = (size_m > room) ? room : size_m;
  assign w_x    = (size_x > room) ? room : size_x;

  for (genvar i = 0; i < DATA_W; i++) begin : g_low
    assign low_m[i] = (CW'(i) < w_m);
    assign low_x[i] = (CW'(i) < w_x);
  end

  assign mask_o = low_m << pos;
  assign ext_o  = (src_a_i >> pos) & low_x;
endmodule

// File: rtl/sbit_quad.sv
module sbit_quad #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   src_i,
  output logic [DATA_W-1:0]   fill_o,
  output logic [DATA_W/4-1:0] pack_o
);
  localparam int GROUPS = DATA_W / 4;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic any;
    assign any            = |src_i[4*g +: 4];
    assign fill_o[4*g +: 4] = {4{any}};
    assign pack_o[g]      = any;
  end
endmodule

// File: rtl/sbit_scan.sv
module sbit_scan #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]  src_i,
  output logic [DATA_W-1:0]  rev_o,
  output logic [$clog2(DATA_W):0]   cnt0_o,
  output logic [$clog2(DATA_W):0]   cnt1_o,
  output logic [$clog2(DATA_W)-1:0] ff0_o,
  output logic                      ff0_hit_o,
  output logic [$clog2(DATA_W)-1:0] ff1_o,
  output logic                      ff1_hit_o,
  output logic [$clog2(DATA_W)-1:0] ldu_o,
  output logic                      ldu_hit_o,
  output logic [$clog2(DATA_W)-1:0] lds_o,
  output logic                      lds_hit_o
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] diff;
  assign diff = src_i ^ {DATA_W{src_i[MSB]}};

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign rev_o[i] = src_i[MSB-i];
  end

  always_comb begin
    cnt0_o = '0;
    cnt1_o = '0;
    for (int i = 0; i < DATA_W; i++) begin
      cnt1_o = cnt1_o + (IDX_W+1)'(src_i[i]);
      cnt0_o = cnt0_o + (IDX_W+1)'(!src_i[i]);
    end
  end

  // downward walk: the last match is the lowest index
  always_comb begin
    ff0_o = '0; ff0_hit_o = 1'b0;
    ff1_o = '0; ff1_hit_o = 1'b0;
    for (int i = MSB; i >= 0; i--) begin
      if (!src_i[i]) begin ff0_o = IDX_W'(i); ff0_hit_o = 1'b1; end
      if (src_i[i])  begin ff1_o = IDX_W'(i); ff1_hit_o = 1'b1; end
    end
  end

  // upward walk: the last match is the highest index
  always_comb begin
    ldu_o = '0; ldu_hit_o = 1'b0;
    lds_o = '0; lds_hit_o = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (src_i[i]) begin ldu_o = IDX_W'(MSB - i); ldu_hit_o = 1'b1; end
      if (i < MSB && diff[i]) begin lds_o = IDX_W'(MSB - i); lds_hit_o = 1'b1; end
    end
  end
endmodule

// File: rtl/sbit_unit.sv
module sbit_unit
  import sbit_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int WID_LSB = 16,
  parameter int WID_W   = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              flag_o
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int GROUPS = DATA_W / 4;

  logic [DATA_W-1:0] f_mask, f_ext, q_fill, s_rev;
  logic [GROUPS-1:0] q_pack;
  logic [IDX_W:0]    s_cnt0, s_cnt1;
  logic [IDX_W-1:0]  s_ff0, s_ff1, s_ldu, s_lds;
  logic              h_ff0, h_ff1, h_ldu, h_lds;

  sbit_field #(.DATA_W(DATA_W), .WID_LSB(WID_LSB), .WID_W(WID_W)) u_field (
    .src_a_i(src_a_i), .src_b_i(src_b_i), .mask_o(f_mask), .ext_o(f_ext)
  );

  sbit_quad #(.DATA_W(DATA_W)) u_quad (
    .src_i(src_a_i), .fill_o(q_fill), .pack_o(q_pack)
  );

  sbit_scan #(.DATA_W(DATA_W)) u_scan (
    .src_i(src_a_i), .rev_o(s_rev),
    .cnt0_o(s_cnt0), .cnt1_o(s_cnt1),
    .ff0_o(s_ff0), .ff0_hit_o(h_ff0),
    .ff1_o(s_ff1), .ff1_hit_o(h_ff1),
    .ldu_o(s_ldu), .ldu_hit_o(h_ldu),
    .lds_o(s_lds), .lds_hit_o(h_lds)
  );

  logic [DATA_W-1:0] res_d;
  logic              flag_d;
  logic [IDX_W-1:0]  idx_sel;
  logic              hit_sel, is_find;

  always_comb begin
    res_d   = '0;
    is_find = 1'b0;
    idx_sel = '0;
    hit_sel = 1'b0;
    case (sbit_op_e'(op_i))
      OP_FMASK: res_d = f_mask;
      OP_FEXT:  res_d = f_ext;
      OP_QFILL: res_d = q_fill;
      OP_QPACK: res_d = DATA_W'(q_pack);
      OP_REV:   res_d = s_rev;
      OP_CNT0:  res_d = DATA_W'(s_cnt0);
      OP_CNT1:  res_d = DATA_W'(s_cnt1);
      OP_FIND0: begin is_find = 1'b1; idx_sel = s_ff0; hit_sel = h_ff0; end
      OP_FIND1: begin is_find = 1'b1; idx_sel = s_ff1; hit_sel = h_ff1; end
      OP_LEADU: begin is_find = 1'b1; idx_sel = s_ldu; hit_sel = h_ldu; end
      OP_LEADS: begin is_find = 1'b1; idx_sel = s_lds; hit_sel = h_lds; end
      default:  res_d = '0;
    endcase
    if (is_find) begin
      res_d  = hit_sel ? DATA_W'(idx_sel) : '1;
      flag_d = hit_sel && (idx_sel != '0);
    end else begin
      flag_d = (res_d != '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flag_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        flag_o   <= flag_d;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(flag_o)));
  a_r11_flag_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> (result_o != '0));
  a_r4_quad_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(q_fill) == 4 * $countones(q_pack));
  a_r7_pop_total: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(s_cnt0) + 32'(s_cnt1)) == 32'(DATA_W));
  a_r8_ff1_hit_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ff1 |-> src_a_i[s_ff1]);
  a_r8_ff0_hit_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_ff0 |-> !src_a_i[s_ff0]);
endmodule

// File: tb/sbit_unit_test.sv
module sbit_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] src_a_i = '0, src_b_i = '0;
  logic        valid_o, flag_o;
  logic [31:0] result_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_res = '0;
  logic        exp_flag = 1'b0;
  logic [3:0]  last_op = '0;

  always #5ns clk = ~clk;

  sbit_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i),
    .valid_o(valid_o), .result_o(result_o), .flag_o(flag_o)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";
      4'd3: return "R5";  4'd4: return "R6";  4'd5, 4'd6: return "R7";
      4'd7, 4'd8: return "R8"; 4'd9: return "R9"; 4'd10: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic void model(input logic [3:0] op, input logic [31:0] a, b,
                                output logic [31:0] r, output logic f);
    int p, w, n;
    r = '0;
    case (op)
      4'd0: begin
        p = int'(b[4:0]); w = int'(a[5:0]);
        if (w > 32 - p) w = 32 - p;
        for (int i = 0; i < w; i++) r[p+i] = 1'b1;
      end
      4'd1: begin
        p = int'(b[4:0]); w = int'(b[22:16]);
        if (w > 32 - p) w = 32 - p;
        for (int i = 0; i < w; i++) r[i] = a[p+i];
      end
      4'd2: for (int g = 0; g < 8; g++) if (a[4*g +: 4] != 0) r[4*g +: 4] = 4'hF;
      4'd3: for (int g = 0; g < 8; g++) r[g] = (a[4*g +: 4] != 0);
      4'd4: for (int i = 0; i < 32; i++) r[i] = a[31-i];
      4'd5, 4'd6: begin
        n = 0;
        for (int i = 0; i < 32; i++) if (a[i] == (op == 4'd6)) n++;
        r = 32'(n);
      end
      4'd7, 4'd8: begin
        r = '1;
        for (int i = 0; i < 32; i++)
          if (a[i] == (op == 4'd8)) begin r = 32'(i); break; end
      end
      4'd9: begin
        r = '1;
        for (int i = 31; i >= 0; i--) if (a[i]) begin r = 32'(31 - i); break; end
      end
      4'd10: begin
        r = '1;
        for (int i = 30; i >= 0; i--) if (a[i] != a[31]) begin r = 32'(31 - i); break; end
      end
      default: r = '0;
    endcase
    if (op >= 4'd7 && op <= 4'd10) f = (r != 0) && (r != 32'hFFFFFFFF);
    else f = (r != 0);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive after a falling edge, check at the next falling edge
  task automatic step(input logic v, input logic [3:0] op, input logic [31:0] a, b);
    logic [31:0] r;
    logic        f;
    valid_i = v; op_i = op; src_a_i = a; src_b_i = b;
    if (v) begin
      model(op, a, b, r, f);
      exp_res = r; exp_flag = f; last_op = op;
    end
    @(negedge clk);
    check("R1", "valid_o", 32'(valid_o), 32'(v));
    check(v ? req_of(op) : "R1", v ? "result" : "held result", result_o, exp_res);
    check(v ? "R11" : "R1", "flag", 32'(flag_o), 32'(exp_flag));
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    // R13 reset state, with a request presented during reset
    valid_i = 1'b1; op_i = 4'd4; src_a_i = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R13", "valid_o", 32'(valid_o), 0);
    check("R13", "result_o", result_o, 0);
    check("R13", "flag_o", 32'(flag_o), 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 field mask corners
    step(1, 0, 32'd40, 32'd4);        // clamped: 0xFFFFFFF0
    step(1, 0, 32'd3, 32'd30);        // clamp to 2 bits
    step(1, 0, 32'd0, 32'd7);         // empty
    step(1, 0, 32'd32, 32'd0);        // full word
    step(0, 0, 32'hFFFF_FFFF, 32'd0); // R1 idle hold
    // R3 extract corners
    step(1, 1, 32'hDEAD_BEEF, 32'h0008_0024); // offset 36 uses low 5 bits -> 4
    step(1, 1, 32'hDEAD_BEEF, 32'h0000_0008); // width 0
    step(1, 1, 32'hDEAD_BEEF, 32'h007F_001C); // width clamped to 4
    step(1, 1, 32'h8000_0000, 32'h0001_001F);
    // R4/R5
    step(1, 2, 32'h0010_0800, 0);
    step(1, 3, 32'hF000_0001, 0);
    step(1, 3, 32'h0, 0);
    // R6/R7
    step(1, 4, 32'h0000_0001, 0);
    step(1, 5, 32'hFFFF_FFFF, 0);
    step(1, 6, 32'hFFFF_FFFF, 0);
    step(1, 5, 32'h0, 0);
    // R8 not-found and index 0
    step(1, 7, 32'hFFFF_FFFF, 0);
    step(1, 8, 32'h0, 0);
    step(1, 8, 32'h1, 0);
    step(1, 7, 32'hFFFF_00FF, 0);
    // R9
    step(1, 9, 32'h0, 0);
    step(1, 9, 32'h8000_0000, 0);
    step(1, 9, 32'h0000_0001, 0);
    // R10
    step(1, 10, 32'hFFFF_FFFF, 0);
    step(1, 10, 32'h0, 0);
    step(1, 10, 32'h4000_0000, 0);
    step(1, 10, 32'h0000_0001, 0);
    step(1, 10, 32'hFFFF_FFFE, 0);
    step(0, 10, 32'h1, 0);
    // R12 unassigned opcodes
    for (int op = 11; op < 16; op++) step(1, 4'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // mixed random traffic across all opcodes with idle gaps
    for (int i = 0; i < 3000; i++) begin
      ra = $urandom();
      rb = $urandom();
      if (i % 5 == 0) ra = ra & 32'h0F0F_0000;
      step(($urandom() % 4) != 0, 4'($urandom() % 16), ra, rb);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule